// File: doc/BRIEF.md
# Multi-Mode PRG Bank Translator

This block turns a CPU address in the upper 32 KiB of the CPU map into an 18-bit PRG-ROM address. It holds six small banking registers: an outer bank register, a two-bit banking mode, and four inner 8 KiB bank registers. Each register loads through a simple write port. Everything between the registers and the output address is combinational, so a new CPU address produces a translated address in the same cycle.

There are three banking schemes:
- **Split-16 mode (mode 0):** a switchable 16 KiB bank at the bottom of the window and a fixed last 16 KiB bank at the top.
- **Wide-32 mode (mode 1):** one 32 KiB bank covering the whole window.
- **Fine-8 mode (modes 2 and 3):** four independent 8 KiB windows, one per inner register.

In every scheme, bit 3 of the outer register selects one of two 128 KiB blocks and becomes address bit 17. All registers reset to all ones. After reset the block is therefore in fine-8 mode, and the topmost 8 KiB window maps to bank 15 of the upper block, so execution can begin from the top of the address space.

The block has no state machine. Its only state is the register file, and each register has two conditions: holding its value, or loading on a write.

Top module: `prg_xlat_top`

## Requirements
- R1: While `rst_n` is low, every register bit is one (outer = 4'hF, mode = 3, every inner = 4'hF). After reset, a CPU offset of 15'h6000+x maps to 18'h3E000+x.
- R2: In mode 0 with `cpu_addr[14]` = 0, `prg_addr` = {outer[3], outer[2:0], cpu_addr[13:0]}.
- R3: In mode 0 with `cpu_addr[14]` = 1, `prg_addr` = {outer[3], 3'b111, cpu_addr[13:0]}, which is the last 16 KiB bank of the selected 128 KiB block.
- R4: In mode 1, `prg_addr` = {outer[3], outer[2:1], cpu_addr[14:0]}.
- R5: In mode 2, `prg_addr` = {outer[3], inner[cpu_addr[14:13]], cpu_addr[12:0]}.
- R6: Mode 3 translates exactly as mode 2 does.
- R7: Writes follow these rules:
  - A write occurs on a rising clock edge with `wr_en` = 1.
  - `wr_sel` = 0 loads the outer register from `wr_data[3:0]`.
  - `wr_sel` = 1 loads the mode from `wr_data[4:3]`.
  - `wr_sel` = 2 to 5 load inner registers 0 to 3 from `wr_data[3:0]`.
  - `wr_sel` = 6 or 7, or `wr_en` = 0, changes no register.
- R8: A register loaded at a clock edge governs `prg_addr` from that edge on. A change of `cpu_addr` alone changes `prg_addr` with no clock delay.
- R9: In every mode, `prg_addr[17]` equals outer bit 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low reset; sets every register bit to one |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0 outer, 1 mode, 2..5 inner 0..3) |
| wr_data | input | 5 | Write data; bits 3:0 bank value, bits 4:3 mode |
| cpu_addr | input | 15 | CPU address offset within the 32 KiB window |
| prg_addr | output | 18 | Translated PRG-ROM address |

## Verification
The assertions check the following on every cycle:
- the block bit,
- the fixed top bank in split-16 mode,
- pass-through of the low 13 offset bits in fine-8 mode,
- that the registers hold when no valid write is presented.

Only the bench's scenarios can show the remaining behaviour: that each bank field comes from the intended register bits, that mode 3 mirrors mode 2, the reset mapping, and the same-cycle effect of a write. The bench checks these by comparing against a behavioural model of the register file and address arithmetic on every clock.

// File: rtl/prg_xlat_pkg.sv
package prg_xlat_pkg;

    typedef enum logic [1:0] {
        PM_SPLIT16   = 2'd0,
        PM_WIDE32    = 2'd1,
        PM_FINE8     = 2'd2,
        PM_FINE8_ALT = 2'd3
    } prg_mode_e;

    typedef enum logic [2:0] {
        SEL_OUTER = 3'd0,
        SEL_MODE  = 3'd1,
        SEL_IN0   = 3'd2,
        SEL_IN1   = 3'd3,
        SEL_IN2   = 3'd4,
        SEL_IN3   = 3'd5
    } reg_sel_e;

    localparam int MODE_LSB = 3;

endpackage

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
    import prg_xlat_pkg::*;
#(
    parameter int BANK_W = 4,
    parameter int NWIN   = 4,
    parameter int SEL_W  = 3,
    parameter int DW     = MODE_LSB + 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [SEL_W-1:0]             wr_sel,
    input  logic [DW-1:0]                wr_data,
    output logic [BANK_W-1:0]            outer_q,
    output prg_mode_e                    mode_q,
    output logic [NWIN-1:0][BANK_W-1:0]  inner_q
);

    localparam int INNER_BASE = 2;

    logic hit_outer;
    logic hit_mode;
    logic valid_sel;

    assign hit_outer = wr_en && (wr_sel == SEL_W'(SEL_OUTER));
    assign hit_mode  = wr_en && (wr_sel == SEL_W'(SEL_MODE));
    assign valid_sel = (int'(wr_sel) < INNER_BASE + NWIN);

    // Outer bank register: resets to all ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outer_q <= '1;
        end else if (hit_outer) begin
            outer_q <= wr_data[BANK_W-1:0];
        end
    end

    // Mode register: resets to all ones (fine-8 alternate).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= PM_FINE8_ALT;
        end else if (hit_mode) begin
            mode_q <= prg_mode_e'(wr_data[MODE_LSB+1:MODE_LSB]);
        end
    end

    // One inner bank register per 8 KiB window.
    for (genvar gi = 0; gi < NWIN; gi++) begin : g_inner
        logic hit_in;
        assign hit_in = wr_en && (wr_sel == SEL_W'(INNER_BASE + gi));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                inner_q[gi] <= '1;
            end else if (hit_in) begin
                inner_q[gi] <= wr_data[BANK_W-1:0];
            end
        end
    end

    // R7
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(outer_q) && $stable(mode_q) && $stable(inner_q)));

    // R7
    unused_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !valid_sel) |=> ($stable(outer_q) && $stable(mode_q) && $stable(inner_q)));

endmodule

// File: rtl/prg_window_mux.sv
module prg_window_mux
    import prg_xlat_pkg::*;
#(
    parameter int CAW    = 15,
    parameter int BANK_W = 4,
    parameter int NWIN   = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CAW-1:0]               cpu_addr,
    input  logic [BANK_W-1:0]            outer_q,
    input  prg_mode_e                    mode_q,
    input  logic [NWIN-1:0][BANK_W-1:0]  inner_q,
    output logic [CAW+BANK_W-$clog2(NWIN):0] prg_addr
);

    localparam int WIN_W   = $clog2(NWIN);
    localparam int OFF8    = CAW - WIN_W;
    localparam int BLK_LOW = OFF8 + BANK_W;
    localparam int B16     = BLK_LOW - (CAW - 1);
    localparam int PAW     = BLK_LOW + 1;

    logic [WIN_W-1:0]   win;
    logic [BLK_LOW-1:0] low;

    assign win = cpu_addr[CAW-1:OFF8];

    always_comb begin
        low = '0;
        unique case (mode_q)
            PM_SPLIT16: begin
                if (cpu_addr[CAW-1]) begin
                    low = {{B16{1'b1}}, cpu_addr[CAW-2:0]};
                end else begin
                    low = {outer_q[B16-1:0], cpu_addr[CAW-2:0]};
                end
            end
            PM_WIDE32: begin
                low = {outer_q[B16-1:1], cpu_addr};
            end
            PM_FINE8, PM_FINE8_ALT: begin
                low = {inner_q[win], cpu_addr[OFF8-1:0]};
            end
            default: low = '0;
        endcase
    end

    assign prg_addr = {outer_q[BANK_W-1], low};

    // R9
    block_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prg_addr[PAW-1] == outer_q[BANK_W-1]);

    // R3
    fixed_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_SPLIT16 && cpu_addr[CAW-1]) |-> (&prg_addr[BLK_LOW-1:CAW-1]));

    // R5
    fine_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[1]) |-> (prg_addr[OFF8-1:0] == cpu_addr[OFF8-1:0]));

endmodule

// File: rtl/prg_xlat_top.sv
module prg_xlat_top
    import prg_xlat_pkg::*;
#(
    parameter int CAW    = 15,
    parameter int BANK_W = 4,
    parameter int NWIN   = 4,
    parameter int SEL_W  = 3,
    parameter int DW     = MODE_LSB + 2,
    parameter int PAW    = CAW + BANK_W - $clog2(NWIN) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [DW-1:0]    wr_data,
    input  logic [CAW-1:0]   cpu_addr,
    output logic [PAW-1:0]   prg_addr
);

    logic [BANK_W-1:0]           outer_q;
    prg_mode_e                   mode_q;
    logic [NWIN-1:0][BANK_W-1:0] inner_q;

    prg_bank_regs #(
        .BANK_W (BANK_W),
        .NWIN   (NWIN),
        .SEL_W  (SEL_W),
        .DW     (DW)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .outer_q (outer_q),
        .mode_q  (mode_q),
        .inner_q (inner_q)
    );

    prg_window_mux #(
        .CAW    (CAW),
        .BANK_W (BANK_W),
        .NWIN   (NWIN)
    ) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_addr (cpu_addr),
        .outer_q  (outer_q),
        .mode_q   (mode_q),
        .inner_q  (inner_q),
        .prg_addr (prg_addr)
    );

endmodule

// File: tb/sim_prg_xlat_top.sv
`timescale 1ns/1ps
module sim_prg_xlat_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [4:0]  wr_data = '0;
    logic [14:0] cpu_addr = '0;
    logic [17:0] prg_addr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // behavioural model state
    int m_outer = 15;
    int m_mode = 3;
    int m_inner[4] = '{15, 15, 15, 15};

    always #2 clk = ~clk;

    prg_xlat_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cpu_addr(cpu_addr), .prg_addr(prg_addr)
    );

    function automatic int model_addr(int a);
        int low;
        if (m_mode == 0) begin
            if (a >= 'h4000) low = (7 << 14) + (a % 'h4000);
            else             low = ((m_outer % 8) << 14) + (a % 'h4000);
        end else if (m_mode == 1) begin
            low = (((m_outer / 2) % 4) << 15) + a;
        end else begin
            low = (m_inner[a / 'h2000] << 13) + (a % 'h2000);
        end
        return ((m_outer / 8) << 17) + low;
    endfunction

    function automatic string tag_of(int a);
        if (m_mode == 0) return (a >= 'h4000) ? "R3" : "R2";
        if (m_mode == 1) return "R4";
        if (m_mode == 2) return "R5";
        return "R6";
    endfunction

    task automatic check(string req, int exp);
        total++;
        if (int'(prg_addr) != exp) begin
            bad++;
            $display("FAIL %s: addr=%h got=%h exp=%h", req, cpu_addr, prg_addr, exp[17:0]);
        end
    endtask

    // One clock: drive at negedge, compare before the edge, update model at edge.
    task automatic cyc(bit en, int sel, int data, int a, string req = "");
        @(negedge clk);
        wr_en = en; wr_sel = 3'(sel); wr_data = 5'(data); cpu_addr = 15'(a);
        #1;
        check((req == "") ? tag_of(a) : req, model_addr(a));
        @(posedge clk);
        if (en) begin
            if (sel == 0) m_outer = data % 16;
            else if (sel == 1) m_mode = (data >> 3) % 4;
            else if (sel >= 2 && sel <= 5) m_inner[sel-2] = data % 16;
        end
    endtask

    task automatic sweep(string req);
        for (int w = 0; w < 8; w++) cyc(0, 0, 0, w * 'h1000 + 'h0ABC + w, req);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: got=timeout exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, even with a write presented during reset
        wr_en = 1; wr_sel = 0; wr_data = 0; cpu_addr = 15'h6123;
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if (prg_addr != 18'h3E123) begin
            bad++;
            $display("FAIL R1: got=%h exp=%h", prg_addr, 18'h3E123);
        end
        wr_en = 0;
        rst_n = 1;
        cyc(0, 0, 0, 'h6000, "R1");
        cyc(0, 0, 0, 'h7FFF, "R1");

        // mode 0 (R2/R3) with several outer values, incl. R8 same-cycle effect
        cyc(1, 1, 0 << 3, 'h0000);
        for (int o = 0; o < 16; o += 5) begin
            cyc(1, 0, o, 'h1234, "R8");
            cyc(0, 0, 0, 'h1234, "R2");
            cyc(0, 0, 0, 'h3FFF, "R2");
            cyc(0, 0, 0, 'h4000, "R3");
            cyc(0, 0, 0, 'h7FFF, "R3");
        end

        // mode 1 (R4)
        cyc(1, 1, 1 << 3, 'h0100);
        for (int o = 0; o < 16; o += 3) begin
            cyc(1, 0, o, 'h2222);
            cyc(0, 0, 0, 'h0001, "R4");
            cyc(0, 0, 0, 'h7FFE, "R4");
        end

        // mode 2 (R5), distinct inner values
        cyc(1, 1, 2 << 3, 'h0000);
        cyc(1, 2, 3, 0); cyc(1, 3, 6, 0); cyc(1, 4, 9, 0); cyc(1, 5, 12, 0);
        cyc(1, 0, 8, 0);
        sweep("R5");
        cyc(1, 0, 0, 0);
        sweep("R5");

        // mode 3 mirrors mode 2 (R6)
        cyc(1, 1, 3 << 3, 0);
        sweep("R6");

        // R7: unused selects and disabled writes change nothing
        cyc(1, 6, 5'h1F, 0, "R7");
        cyc(1, 7, 5'h00, 0, "R7");
        cyc(0, 0, 5'h07, 0, "R7");
        cyc(0, 1, 5'h00, 0, "R7");
        sweep("R7");
        cyc(1, 1, 0, 'h4567, "R7");
        sweep("R7");

        // R9 and mixed traffic: pseudo-random writes and addresses
        for (int i = 0; i < 3000; i++) begin
            int r = int'($urandom);
            cyc((r % 4) == 0, (r >> 4) % 8, (r >> 8) % 32, (r >> 13) % 'h8000);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule